// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two 16-bit ports, called A and B, with a storage register on each side. One register samples the A port and the other samples the B port, each when its own capture strobe rises. A per-half active-low enable and a shared direction input pick which port is driven. For each direction, a select input chooses whether the driven port carries the live value arriving at the opposite port or the value held in the matching register.

The width is split into two 8-bit halves. Each half has its own enable, its own pair of capture strobes and its own pair of path selects. When a half's enable is inactive, that half drives neither port, but its registers keep capturing. Ports are modelled as separate input, output and output-enable vectors rather than tristate nets. An undriven port's output reads as zero. The capture strobes are ordinary signals sampled on the system clock. A rising edge is one sample low followed by one sample high.

Top module: `regbus_xcvr`

## Requirements
- R1: The A-side register of a half loads that half of `a_in` at the clock edge where `a_cap` for the half was low at the previous edge and is high now. A strobe held high or falling loads nothing.
- R2: The B-side register of a half loads that half of `b_in` under the same rising-strobe rule, using `b_cap`.
- R3: While `oe_n` for a half is 1, `a_oe` and `b_oe` for that half are 0, and that half of `a_out` and of `b_out` is zero.
- R4: While a half is isolated, its registers still capture on rising strobes. The captured values appear once the half is enabled and the stored path is selected.
- R5: While `oe_n` for a half is 0, `dir`=1 sets `b_oe` for that half (A drives B), and `dir`=0 sets `a_oe` for that half. The two are never set together.
- R6: With the path select at 0 (live), the driven port's half equals the opposite port's input half in the same cycle.
- R7: With the path select at 1 (stored), the driven port's half equals the register of the opposite side: `sel_ab` picks the A-side register for B, and `sel_ba` picks the B-side register for A.
- R8: If a register loads in a cycle where its stored path is driven, the output shows the old value in that cycle and the new value from the next cycle on.
- R9: The enable, strobes and selects of one half leave the other half's outputs and registers unchanged. Bits 7:0 form half 0 and bits 15:8 form half 1.
- R10: A low `rst_n` at a clock edge clears both registers of both halves to zero.
- R11: Rising strobes on both sides in the same cycle load both registers, each from its own port.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-half active-low output enable |
| dir | input | 1 | 1: A drives B, 0: B drives A (shared by both halves) |
| a_cap | input | 2 | Per-half strobe that captures the A port into the A-side register |
| b_cap | input | 2 | Per-half strobe that captures the B port into the B-side register |
| sel_ab | input | 2 | Per-half path select toward B: 0 live A, 1 A-side register |
| sel_ba | input | 2 | Per-half path select toward A: 0 live B, 1 B-side register |
| a_in | input | 16 | Data arriving on port A |
| b_in | input | 16 | Data arriving on port B |
| a_out | output | 16 | Data driven onto port A, zero where not driven |
| a_oe | output | 2 | Per-half drive enable of port A |
| b_out | output | 16 | Data driven onto port B, zero where not driven |
| b_oe | output | 2 | Per-half drive enable of port B |

## Verification
The hardest case to reach from the ports is a register load in the very cycle its stored path is on the driven port. The old value is visible for only one cycle before the new one replaces it. The stimulus sets up the stored path first. It then raises the strobe together with a new input value and samples the driven output before that clock edge and again after it. Isolated capture is reached by loading both registers with the enables inactive, then opening the halves one at a time.

// File: rtl/xcvr_pkg.sv
// Package: shared defaults and the path-select encoding of the transceiver.
// Assumes nothing; it only holds constants and types.
package xcvr_pkg;

    localparam int DEF_HALF_W  = 8;
    localparam int DEF_HALVES  = 2;

    // Source chosen for the driven port.
    typedef enum logic {
        PATH_LIVE   = 1'b0,
        PATH_STORED = 1'b1
    } path_sel_e;

endpackage

// File: rtl/xcvr_strobe_edge.sv
// Module: turns level strobes sampled on clk into one-cycle rise flags.
// Assumes the strobes are synchronous to clk. The previous sample clears to
// zero on reset, so a strobe already high after reset counts as a rise.
module xcvr_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    // Keep the strobe sample from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= strobe;
    end

    // Flag a rise where the strobe is high now and was low at the last edge.
    always_comb begin
        rise = strobe & ~prev_q;
    end

endmodule

// File: rtl/xcvr_store_reg.sv
// Module: a data register with a load enable and synchronous active-low clear.
// Assumes load is already a single-cycle pulse.
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold the value; take d on load; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/xcvr_half_lane.sv
// Module: one independent half of the transceiver. Two registers, two
// live/stored multiplexers and the output gating for both ports.
// Assumes the drive_a and drive_b flags are never set together.
module xcvr_half_lane
    import xcvr_pkg::*;
#(
    parameter int W = DEF_HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_a,
    input  logic         load_b,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         drive_a,
    input  logic         drive_b,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out
);

    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;
    logic [W-1:0] toward_b;
    logic [W-1:0] toward_a;

    xcvr_store_reg #(.W(W)) u_reg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_a),
        .d     (a_in),
        .q     (reg_a)
    );

    xcvr_store_reg #(.W(W)) u_reg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_b),
        .d     (b_in),
        .q     (reg_b)
    );

    // Pick live A or the A-side register for the B port.
    always_comb begin
        if (path_sel_e'(sel_ab) == PATH_STORED) toward_b = reg_a;
        else                                    toward_b = a_in;
    end

    // Pick live B or the B-side register for the A port.
    always_comb begin
        if (path_sel_e'(sel_ba) == PATH_STORED) toward_a = reg_b;
        else                                    toward_a = b_in;
    end

    // Zero any port that this half does not drive.
    always_comb begin
        a_out = drive_a ? toward_a : '0;
        b_out = drive_b ? toward_b : '0;
    end

endmodule

// File: rtl/regbus_xcvr.sv
// Module: registered bidirectional transceiver made of independent halves.
// Assumes the strobe inputs are synchronous to clk and that the two sides of
// each port are wired externally. Direction is shared by all halves.
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W,
    parameter int HALVES = DEF_HALVES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HALVES-1:0]        oe_n,
    input  logic                     dir,
    input  logic [HALVES-1:0]        a_cap,
    input  logic [HALVES-1:0]        b_cap,
    input  logic [HALVES-1:0]        sel_ab,
    input  logic [HALVES-1:0]        sel_ba,
    input  logic [HALVES*HALF_W-1:0] a_in,
    input  logic [HALVES*HALF_W-1:0] b_in,
    output logic [HALVES*HALF_W-1:0] a_out,
    output logic [HALVES-1:0]        a_oe,
    output logic [HALVES*HALF_W-1:0] b_out,
    output logic [HALVES-1:0]        b_oe
);

    localparam int BUS_W = HALVES * HALF_W;

    logic [HALVES-1:0] rise_a;
    logic [HALVES-1:0] rise_b;
    logic [HALVES-1:0] drive_a;
    logic [HALVES-1:0] drive_b;
    logic [BUS_W-1:0]  a_out_w;
    logic [BUS_W-1:0]  b_out_w;

    xcvr_strobe_edge #(.N(HALVES)) u_edge_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (a_cap),
        .rise   (rise_a)
    );

    xcvr_strobe_edge #(.N(HALVES)) u_edge_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (b_cap),
        .rise   (rise_b)
    );

    // Decode the per-half enable and the shared direction into port drives.
    always_comb begin
        drive_b = ~oe_n & {HALVES{dir}};
        drive_a = ~oe_n & {HALVES{~dir}};
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        xcvr_half_lane #(.W(HALF_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_a  (rise_a[h]),
            .load_b  (rise_b[h]),
            .sel_ab  (sel_ab[h]),
            .sel_ba  (sel_ba[h]),
            .drive_a (drive_a[h]),
            .drive_b (drive_b[h]),
            .a_in    (a_in[h*HALF_W +: HALF_W]),
            .b_in    (b_in[h*HALF_W +: HALF_W]),
            .a_out   (a_out_w[h*HALF_W +: HALF_W]),
            .b_out   (b_out_w[h*HALF_W +: HALF_W])
        );
    end

    // Route the lane results and drive flags to the ports.
    always_comb begin
        a_out = a_out_w;
        b_out = b_out_w;
        a_oe  = drive_a;
        b_oe  = drive_b;
    end

endmodule

// File: rtl/regbus_xcvr_chk.sv
// Module: property checker for regbus_xcvr, attached with bind below.
// Assumes the strobe inputs are sampled on clk. A small warm-up counter keeps
// properties that look two samples back quiet just after reset.
module regbus_xcvr_chk #(
    parameter int HALF_W = 8,
    parameter int HALVES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [HALVES-1:0]        oe_n,
    input logic                     dir,
    input logic [HALVES-1:0]        a_cap,
    input logic [HALVES-1:0]        b_cap,
    input logic [HALVES-1:0]        sel_ab,
    input logic [HALVES-1:0]        sel_ba,
    input logic [HALVES*HALF_W-1:0] a_in,
    input logic [HALVES*HALF_W-1:0] b_in,
    input logic [HALVES*HALF_W-1:0] a_out,
    input logic [HALVES-1:0]        a_oe,
    input logic [HALVES*HALF_W-1:0] b_out,
    input logic [HALVES-1:0]        b_oe
);

    logic [1:0] warm_q;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_chk
        // R3: an isolated half drives nothing
        a_r3_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[h] |-> (!a_oe[h] && !b_oe[h] &&
                         a_out[h*HALF_W +: HALF_W] == '0 &&
                         b_out[h*HALF_W +: HALF_W] == '0));

        // R5: an enabled half drives exactly the port set by dir
        a_r5_direction: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_n[h] |-> (b_oe[h] == dir && a_oe[h] == !dir));

        // R1: after a rising A strobe, the stored B path shows the sampled A data
        a_r1_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2 && $past(a_cap[h]) && !$past(a_cap[h], 2) &&
             b_oe[h] && sel_ab[h])
            |-> b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));

        // R2: after a rising B strobe, the stored A path shows the sampled B data
        a_r2_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2 && $past(b_cap[h]) && !$past(b_cap[h], 2) &&
             a_oe[h] && sel_ba[h])
            |-> a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W]));

        // R7: with no rise, the stored path toward B holds its value
        a_r7_stored_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && b_oe[h] && sel_ab[h] &&
             $past(b_oe[h] && sel_ab[h]) &&
             !($past(a_cap[h]) && !$past(a_cap[h], 2)))
            |-> $stable(b_out[h*HALF_W +: HALF_W]));
    end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) u_chk (.*);

// File: tb/regbus_xcvr_bench.sv
// Bench for regbus_xcvr: a vector table walked by one loop, then directed
// tests. Expected values come from a bench-side model of the requirements.
module regbus_xcvr_bench;

    localparam int HW = 8;
    localparam int NH = 2;
    localparam int BW = HW * NH;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NH-1:0] oe_n, a_cap, b_cap, sel_ab, sel_ba;
    logic          dir;
    logic [BW-1:0] a_in, b_in;
    logic [BW-1:0] a_out, b_out;
    logic [NH-1:0] a_oe, b_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [BW-1:0] m_ra, m_rb;  // model of the two registers

    always #4 clk = ~clk;  // 125 MHz

    regbus_xcvr u_regbus_xcvr (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .a_cap(a_cap), .b_cap(b_cap), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct packed {
        logic [1:0]  oe_n;
        logic        dir;
        logic [1:0]  sab;
        logic [1:0]  sba;
        logic [15:0] a;
        logic [15:0] b;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b1, 2'b00, 2'b00, 16'h1234, 16'hFFFF},
        '{2'b00, 1'b0, 2'b00, 2'b00, 16'h0F0F, 16'hBEEF},
        '{2'b00, 1'b1, 2'b11, 2'b00, 16'h7777, 16'h0000},
        '{2'b00, 1'b0, 2'b00, 2'b11, 16'h1111, 16'h2222},
        '{2'b01, 1'b1, 2'b10, 2'b00, 16'h4321, 16'h8888},
        '{2'b10, 1'b0, 2'b01, 2'b10, 16'hCAFE, 16'hD00D},
        '{2'b11, 1'b1, 2'b11, 2'b11, 16'hFFFF, 16'hFFFF},
        '{2'b00, 1'b1, 2'b01, 2'b10, 16'h5A5A, 16'h9999}
    };

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of both ports from the current inputs and the model registers.
    task automatic check_model(input string tag);
        logic [BW-1:0] ea, eb;
        logic [NH-1:0] eao, ebo;
        for (int h = 0; h < NH; h++) begin
            ebo[h] = !oe_n[h] && dir;
            eao[h] = !oe_n[h] && !dir;
            eb[h*HW +: HW] = ebo[h] ? (sel_ab[h] ? m_ra[h*HW +: HW] : a_in[h*HW +: HW]) : '0;
            ea[h*HW +: HW] = eao[h] ? (sel_ba[h] ? m_rb[h*HW +: HW] : b_in[h*HW +: HW]) : '0;
        end
        check({tag, " b_out"}, b_out, eb);
        check({tag, " a_out"}, a_out, ea);
        check({tag, " oe"}, {{(BW-2*NH){1'b0}}, a_oe, b_oe}, {{(BW-2*NH){1'b0}}, eao, ebo});
    endtask

    // Called just after a negedge: pulse the strobes for one cycle.
    task automatic capture(input logic [NH-1:0] ma, input logic [NH-1:0] mb,
                           input logic [BW-1:0] av, input logic [BW-1:0] bv);
        a_in = av; b_in = bv; a_cap = ma; b_cap = mb;
        @(negedge clk);
        for (int h = 0; h < NH; h++) begin
            if (ma[h]) m_ra[h*HW +: HW] = av[h*HW +: HW];
            if (mb[h]) m_rb[h*HW +: HW] = bv[h*HW +: HW];
        end
        a_cap = '0; b_cap = '0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; oe_n = '1; dir = 1'b1; a_cap = '0; b_cap = '0;
        sel_ab = '0; sel_ba = '0; a_in = '0; b_in = '0;
        m_ra = '0; m_rb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state of both registers seen through the stored paths
        oe_n = 2'b00; dir = 1'b1; sel_ab = 2'b11; a_in = 16'hFFFF; #2;
        check("R10 reset reg A", b_out, 16'h0000);
        dir = 1'b0; sel_ba = 2'b11; b_in = 16'hFFFF; #2;
        check("R10 reset reg B", a_out, 16'h0000);
        @(negedge clk);

        // R11: both registers load in the same cycle
        capture(2'b11, 2'b11, 16'hA55A, 16'h3CC3);
        dir = 1'b1; #2; check("R11 reg A", b_out, 16'hA55A);
        dir = 1'b0; #2; check("R11 reg B", a_out, 16'h3CC3);
        @(negedge clk);

        // R3 R5 R6 R7 R9: vector table
        foreach (VECS[i]) begin
            oe_n = VECS[i].oe_n; dir = VECS[i].dir;
            sel_ab = VECS[i].sab; sel_ba = VECS[i].sba;
            a_in = VECS[i].a; b_in = VECS[i].b;
            #2;
            check_model($sformatf("R3/R5/R6/R7/R9 vec %0d", i));
            @(negedge clk);
        end

        // R9: load only half 0 of A; half 1 keeps 0xA5
        oe_n = 2'b00; dir = 1'b1; sel_ab = 2'b11;
        capture(2'b01, 2'b00, 16'h1122, 16'h0000);
        #2; check("R9 half isolation", b_out, 16'hA522);
        @(negedge clk);

        // R1: strobe held high does not reload
        a_in = 16'h6666; a_cap = 2'b11;
        @(negedge clk);
        a_in = 16'h9999;
        @(negedge clk); #2;
        check("R1 held strobe", b_out, 16'h6666);
        a_cap = 2'b00; @(negedge clk); #2;
        check("R1 falling strobe", b_out, 16'h6666);
        m_ra = 16'h6666;

        // R2: B register loads on rise, seen on A
        dir = 1'b0; sel_ba = 2'b11;
        capture(2'b00, 2'b11, 16'h0000, 16'h4D4D);
        #2; check("R2 reg B load", a_out, 16'h4D4D);

        // R8: load while the stored path is driven
        dir = 1'b1; sel_ab = 2'b11; @(negedge clk);
        a_in = 16'hC001; a_cap = 2'b11; #2;
        check("R8 old value same cycle", b_out, 16'h6666);
        @(negedge clk); #2;
        check("R8 new value next cycle", b_out, 16'hC001);
        a_cap = 2'b00; m_ra = 16'hC001; @(negedge clk);

        // R4: capture while isolated, R3 outputs stay zero
        oe_n = 2'b11;
        a_in = 16'hBEAD; b_in = 16'hF00F; a_cap = 2'b11; b_cap = 2'b11; #2;
        check("R3 isolated b_out", b_out, 16'h0000);
        check("R3 isolated a_out", a_out, 16'h0000);
        @(negedge clk); a_cap = '0; b_cap = '0; @(negedge clk);
        oe_n = 2'b00; dir = 1'b1; sel_ab = 2'b11; a_in = '0; #2;
        check("R4 isolated capture A", b_out, 16'hBEAD);
        dir = 1'b0; sel_ba = 2'b11; b_in = '0; #2;
        check("R4 isolated capture B", a_out, 16'hF00F);
        @(negedge clk);

        // R10: reset in mid-run clears stored values
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #2;
        check("R10 mid-run reset B", a_out, 16'h0000);
        dir = 1'b1; #2;
        check("R10 mid-run reset A", b_out, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule